// File: doc/BRIEF.md
# Programmable Interval Timer Counter Channel

This block is one 16-bit down-counting channel of an interval timer, together with the decoder for its 8-bit control word. Software reaches it through a single 8-bit bus with two addresses. One address takes control words. The other is a data port, and the 16-bit count moves through it one byte at a time: the low byte first, then the high byte. The count steps down by one on each cycle in which the tick-enable input is high. That input is nominally pulsed at 1.19318 MHz by a divider outside the block.

A control word can do one of two things. It can select the counting mode, or it can freeze a snapshot of the count so that software reads a value that stays consistent across both bytes. Modes 0, 2 and 3 are accepted. In mode 0 the output level goes high when the count expires. In modes 2 and 3 expiry leaves the output unchanged. Writing the low byte of a new count halts the countdown and forces the output low. Writing the high byte completes the count and starts counting again.

A control word the channel does not support raises a one-cycle error pulse and is otherwise discarded. Unsupported words are the read-back select, a BCD count, a byte-access type other than low-then-high, and a mode outside 0, 2 and 3. Control words addressed to another channel are ignored.

Top module: `pit_channel`

## Requirements
- R1: After reset the count is 0, the output level is low, both byte pointers point at the low byte, no snapshot is held, cfg_err is low and rdata is 0.
- R2: The control word is decoded as select = bits 7:6, access = bits 5:4, mode = bits 3:1 and BCD = bit 0. A word whose select is neither this channel (CHAN_ID, default 0) nor 3 has no effect and raises no error.
- R3: A control word with select 3 is invalid. So is a word for this channel whose access is not 0 and where access differs from 3, or BCD is 1, or mode is not 0, 2 or 3. An invalid word makes cfg_err high for exactly the one cycle after the write and leaves the mode unchanged.
- R4: Access 0 is a latch command. If no snapshot is pending, it copies the current count into the snapshot and resets the read pointer to the low byte. If a snapshot is already pending, it does nothing. While a snapshot is pending, reads return the snapshot. The snapshot is released once its high byte has been read.
- R5: Reads on the data port alternate low byte, then high byte. rdata shows the byte in the cycle after rd_en. With no snapshot pending, a read returns the live, decrementing count.
- R6: A data write while the write pointer is at the low byte does four things: it replaces the low byte of the count, stops any countdown, makes the output low from the next cycle and moves the write pointer to the high byte.
- R7: A data write while the write pointer is at the high byte does three things: it replaces the high byte, starts the countdown if the 16-bit count is nonzero and returns the write pointer to the low byte. A count of zero leaves the channel idle.
- R8: While counting, each cycle with tick_en high lowers the count by one. Without a tick or a data write the count holds. Counting stops when the count reaches zero.
- R9: In mode 0 the output goes high in the cycle after the tick that brings the count to zero. In modes 2 and 3 that tick leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-tick enable, one pulse per timer tick |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (acts on the data port only) |
| addr_ctrl | input | 1 | 1 selects the control register, 0 the data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| out_level | output | 1 | Counter output level |
| cfg_err | output | 1 | One-cycle pulse for an unsupported control word |

## Verification
The countdown is driven by tick bursts of several lengths, and the live count is read between bursts. This separates a correct decrement from a counter that is stuck, counts too far or wraps below zero. Snapshot reads are interleaved with ticks: repeated latch commands, a latch issued mid-pair and a latch aimed at another channel. These show whether the snapshot is taken once, whether the read pointer is reset and whether the snapshot is released after its high byte. Each invalid control word is followed by a one-tick count in a mode-0-looking encoding. An accepted word would make the output rise, so this catches words that were wrongly accepted. Finally, zero counts, a low-byte write in the middle of a countdown, and mode 2 and mode 3 expiries separate the rules for starting, stopping and driving the output.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } access_e;

    typedef struct packed {
        logic [1:0] sel;
        access_e    acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } byte_ptr_e;

    localparam logic [1:0] SEL_READBACK = 2'd3;
endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_byte,
    output logic              latch_cmd,
    output logic              mode_ld,
    output logic [2:0]        mode_val,
    output logic              cfg_err
);
    localparam logic [1:0] MY_SEL = CHAN_ID[1:0];

    typedef struct packed {
        logic err;
    } dec_state_t;

    dec_state_t st_d, st_q;
    ctrl_word_t cw;
    logic       hit, readback, mode_ok, bad;

    always_comb begin
        cw       = ctrl_word_t'(ctrl_byte);
        readback = (cw.sel == SEL_READBACK);
        hit      = (cw.sel == MY_SEL) && !readback;
        mode_ok  = (cw.mode == 3'd0) || (cw.mode == 3'd2) || (cw.mode == 3'd3);
        bad      = ctrl_wr && (readback ||
                   (hit && (cw.acc != ACC_LATCH) &&
                    ((cw.acc != ACC_WORD) || cw.bcd || !mode_ok)));
        latch_cmd = ctrl_wr && hit && (cw.acc == ACC_LATCH);
        mode_ld   = ctrl_wr && hit && (cw.acc != ACC_LATCH) && !bad;
        mode_val  = cw.mode;
        st_d.err  = bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_err = st_q.err;
endmodule

// File: rtl/pit_byte_seq.sv
module pit_byte_seq
    import pit_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_wr,
    input  logic                data_rd,
    input  logic                latch_cmd,
    input  logic [2*DATA_W-1:0] cnt,
    output logic                ld_lo,
    output logic                ld_hi,
    output logic                wr_at_hi,
    output logic [DATA_W-1:0]   rdata
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        byte_ptr_e          wptr;
        byte_ptr_e          rptr;
        logic               held;
        logic [CNT_W-1:0]   snap;
        logic [DATA_W-1:0]  rd;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [CNT_W-1:0] src;

    always_comb begin
        st_d = st_q;
        src  = '0;
        if (data_wr) begin
            st_d.wptr = (st_q.wptr == PTR_LO) ? PTR_HI : PTR_LO;
        end
        if (latch_cmd && !st_q.held) begin
            st_d.held = 1'b1;
            st_d.snap = cnt;
            st_d.rptr = PTR_LO;
        end
        if (data_rd) begin
            src = st_d.held ? st_d.snap : cnt;
            if (st_d.rptr == PTR_LO) begin
                st_d.rd   = src[DATA_W-1:0];
                st_d.rptr = PTR_HI;
            end else begin
                st_d.rd   = src[CNT_W-1:DATA_W];
                st_d.rptr = PTR_LO;
                st_d.held = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wptr: PTR_LO, rptr: PTR_LO, held: 1'b0, snap: '0, rd: '0};
        else        st_q <= st_d;
    end

    assign ld_lo    = data_wr && (st_q.wptr == PTR_LO);
    assign ld_hi    = data_wr && (st_q.wptr == PTR_HI);
    assign wr_at_hi = (st_q.wptr == PTR_HI);
    assign rdata    = st_q.rd;
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
    import pit_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                mode_ld,
    input  logic [2:0]          mode_val,
    output logic [2*DATA_W-1:0] cnt,
    output logic [2:0]          mode,
    output logic                out_level
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             out;
        logic [2:0]       mode;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_ld) st_d.mode = mode_val;
        if (ld_lo) begin
            st_d.cnt[DATA_W-1:0] = wdata;
            st_d.run = 1'b0;
            st_d.out = 1'b0;
        end else if (ld_hi) begin
            st_d.cnt[CNT_W-1:DATA_W] = wdata;
            st_d.run = ({wdata, st_q.cnt[DATA_W-1:0]} != '0);
        end else if (tick && st_q.run) begin
            if (st_q.cnt == ONE) begin
                st_d.cnt = '0;
                st_d.run = 1'b0;
                if (st_q.mode == 3'd0) st_d.out = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign mode      = st_q.mode;
    assign out_level = st_q.out;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CHAN_ID = 0,
    parameter int DATA_W  = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              out_level,
    output logic              cfg_err
);
    localparam int CNT_W = 2 * DATA_W;

    logic             latch_cmd, mode_ld, ld_lo, ld_hi, wr_hi_w;
    logic [2:0]       mode_val, mode_w;
    logic [CNT_W-1:0] cnt_w;

    pit_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_en && addr_ctrl),
        .ctrl_byte (wdata[BYTE_W-1:0]),
        .latch_cmd (latch_cmd),
        .mode_ld   (mode_ld),
        .mode_val  (mode_val),
        .cfg_err   (cfg_err)
    );

    pit_byte_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (wr_en && !addr_ctrl),
        .data_rd   (rd_en && !addr_ctrl),
        .latch_cmd (latch_cmd),
        .cnt       (cnt_w),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .wr_at_hi  (wr_hi_w),
        .rdata     (rdata)
    );

    pit_count_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .wdata     (wdata),
        .mode_ld   (mode_ld),
        .mode_val  (mode_val),
        .cnt       (cnt_w),
        .mode      (mode_w),
        .out_level (out_level)
    );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             wr_en,
    input logic             addr_ctrl,
    input logic             out_level,
    input logic             cfg_err,
    input logic [CNT_W-1:0] cnt,
    input logic [2:0]       mode,
    input logic             wr_hi
);
    assert_out_low_after_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_ctrl && !wr_hi) |=> !out_level);

    assert_out_rise_mode0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_level) |-> ($past(tick_en) && $past(mode) == 3'd0));

    assert_err_after_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(wr_en && addr_ctrl));

    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(wr_en && !addr_ctrl)) |=> $stable(cnt));

    assert_no_increase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > $past(cnt)) |-> $past(wr_en && !addr_ctrl));
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(2 * DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .addr_ctrl (addr_ctrl),
    .out_level (out_level),
    .cfg_err   (cfg_err),
    .cnt       (cnt_w),
    .mode      (mode_w),
    .wr_hi     (wr_hi_w)
);

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr_ctrl = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       out_level, cfg_err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;

    always #5 clk = ~clk;

    pit_channel dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr_ctrl(addr_ctrl), .wdata(wdata),
        .rdata(rdata), .out_level(out_level), .cfg_err(cfg_err)
    );

    // Monitor: compare each read byte in the cycle after its strobe
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5: unexpected read data %0h, expected none", rdata);
            end else begin
                e = exp_q.pop_front();
                if (rdata !== e.val) begin
                    errors++;
                    $display("FAIL %s: rdata %02h expected %02h", e.req, rdata, e.val);
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // All driver tasks start and end on a falling edge
    task automatic wr(input logic ctrl, input logic [7:0] d);
        wr_en = 1'b1; addr_ctrl = ctrl; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr_ctrl = 1'b0;
    endtask

    task automatic rd(input logic [7:0] e, input string req);
        exp_t x;
        x.val = e; x.req = req;
        exp_q.push_back(x);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(1'b0, v[7:0]);
        wr(1'b0, v[15:8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_level, 1'b0, "R1 out after reset");
        chk(cfg_err, 1'b0, "R1 err after reset");
        rd(8'h00, "R1 count low");
        rd(8'h00, "R1 count high");

        // R2/R7/R8/R9 mode 0 countdown with live reads (R5)
        wr(1'b1, 8'h30);
        chk(cfg_err, 1'b0, "R2 valid word");
        load(16'h0005);
        ticks(2);
        rd(8'h03, "R5 live low");
        rd(8'h00, "R5 live high");
        chk(out_level, 1'b0, "R9 out before expiry");
        ticks(3);
        chk(out_level, 1'b1, "R9 out high at expiry mode0");
        ticks(2);
        rd(8'h00, "R8 stops at zero low");
        rd(8'h00, "R8 stops at zero high");
        chk(out_level, 1'b1, "R9 out stays high");

        // R4 latch behaviour
        load(16'h1234);
        ticks(4);
        wr(1'b1, 8'h00);
        ticks(5);
        rd(8'h30, "R4 snapshot low");
        rd(8'h12, "R4 snapshot high");
        rd(8'h2B, "R4 released live low");
        rd(8'h12, "R4 released live high");
        wr(1'b1, 8'h00);
        ticks(1);
        wr(1'b1, 8'h00);
        rd(8'h2B, "R4 second latch ignored low");
        rd(8'h12, "R4 second latch ignored high");
        rd(8'h2A, "R4 live after release low");
        rd(8'h12, "R4 live after release high");
        rd(8'h2A, "R5 live low before mid latch");
        wr(1'b1, 8'h00);
        ticks(1);
        rd(8'h2A, "R4 pointer reset to low");
        rd(8'h12, "R4 mid latch high");
        rd(8'h29, "R5 live low");
        rd(8'h12, "R5 live high");

        // R6 low byte write mid-countdown
        load(16'h0003);
        ticks(3);
        chk(out_level, 1'b1, "R9 out high before low write");
        wr(1'b0, 8'h08);
        chk(out_level, 1'b0, "R6 out forced low");
        ticks(5);
        rd(8'h08, "R6 count halted low");
        rd(8'h00, "R6 count halted high");
        wr(1'b0, 8'h00);
        ticks(7);
        chk(out_level, 1'b0, "R8 out low one before expiry");
        ticks(1);
        chk(out_level, 1'b1, "R7 restart then expiry");

        // R9 modes 2 and 3 leave output unchanged
        wr(1'b1, 8'h34);
        chk(out_level, 1'b1, "R2 control word keeps out");
        load(16'h0002);
        ticks(3);
        chk(out_level, 1'b0, "R9 mode2 expiry no rise");
        rd(8'h00, "R8 mode2 reached zero");
        rd(8'h00, "R8 mode2 reached zero high");
        wr(1'b1, 8'h36);
        load(16'h0002);
        ticks(3);
        chk(out_level, 1'b0, "R9 mode3 expiry no rise");

        // R3 invalid words: error pulse, mode kept (still 3)
        wr(1'b1, 8'h31);
        chk(cfg_err, 1'b1, "R3 BCD error");
        @(negedge clk);
        chk(cfg_err, 1'b0, "R3 error lasts one cycle");
        load(16'h0001);
        ticks(1);
        chk(out_level, 1'b0, "R3 BCD word left mode");
        wr(1'b1, 8'h10);
        chk(cfg_err, 1'b1, "R3 low-only access error");
        wr(1'b1, 8'h32);
        chk(cfg_err, 1'b1, "R3 mode 1 error");
        wr(1'b1, 8'hC0);
        chk(cfg_err, 1'b1, "R3 readback select error");
        load(16'h0001);
        ticks(1);
        chk(out_level, 1'b0, "R3 mode unchanged after errors");

        // R2 other channel words ignored
        wr(1'b1, 8'h70);
        chk(cfg_err, 1'b0, "R2 other channel no error");
        load(16'h0001);
        ticks(1);
        chk(out_level, 1'b0, "R2 other channel mode ignored");
        wr(1'b1, 8'h30);
        load(16'h0100);
        ticks(2);
        wr(1'b1, 8'h40);
        ticks(1);
        rd(8'hFD, "R2 other channel latch ignored low");
        rd(8'h00, "R2 other channel latch ignored high");

        // R7 zero count stays idle
        load(16'h0000);
        chk(out_level, 1'b0, "R6 out low after zero load");
        ticks(3);
        chk(out_level, 1'b0, "R7 zero count idle out");
        rd(8'h00, "R7 zero count low");
        rd(8'h00, "R7 zero count high");

        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5: %0d reads pending, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule